// File: doc/BRIEF.md
# Keyed Watchdog Timer with NMI Warning

This block is a hardware watchdog. An 8-bit down-counter is stepped by a slow tick, and a fixed prescaler derives that tick from the system clock. Software drives the watchdog with one control write. The write carries a start value, a command bit (start or stop) and a 7-bit key. A write takes effect only when its key is the bitwise inverse of the key accepted last. A runaway program that repeats the same write therefore cannot keep the watchdog alive, and it cannot switch the watchdog off.

While the counter runs it moves down by one on every tick. When it steps down to 1, the block sends a one-cycle non-maskable interrupt request. This gives firmware a last chance to save state. When it reaches 0, the block drives the chip reset for a fixed number of clocks and then returns to the stopped state.

The design is a three-state machine with these states:

- `WD_IDLE`: stopped.
- `WD_RUN`: counting.
- `WD_BITE`: holding reset.

It has these transitions:

- `WD_IDLE -> WD_RUN`: accepted start with a non-zero value.
- `WD_IDLE/WD_RUN -> WD_BITE`: accepted start with value 0.
- `WD_RUN -> WD_RUN`: reload on a kick, or a decrement on a tick.
- `WD_RUN -> WD_IDLE`: accepted stop.
- `WD_RUN -> WD_BITE`: tick at count 1.
- `WD_BITE -> WD_IDLE`: end of the reset hold.

Status outputs show the running flag, the count, the stored key and a sticky bad-key flag.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped. Count, stored key, bad-key flag, NMI request and chip reset are all 0.
- R2: An accepted start loads `wr_count` into the counter, sets `st_running` and clears the prescaler. The first decrement happens exactly DIV clocks after the accepting edge, and each later decrement follows DIV clocks after the one before.
- R3: A write (`wr_en`=1) is accepted only when `wr_key` equals the bitwise inverse of the stored key. The accepted key then becomes the stored key, so the first accepted write after reset carries 7'h7F.
- R4: A write with a wrong key leaves the count, the running state and the stored key unchanged. It sets `st_bad_key`, which stays set until reset.
- R5: An accepted start (`wr_start`=1) while running reloads the count and restarts the prescaler (a kick).
- R6: An accepted stop (`wr_start`=0) clears `st_running`, and the count then stays frozen. A stop with a wrong key has no effect on running.
- R7: `nmi_req` is high for exactly one clock when a tick steps the count from 2 to 1. Loading a value does not raise it.
- R8: When a tick steps the count from 1 to 0, or a start loads 0, `chip_rst` is high for exactly HOLD clocks starting the next cycle. While `chip_rst` is high, `st_running` is low. Afterwards the block is stopped with count 0.
- R9: Writes made while `chip_rst` is high are discarded. They change neither the stored key nor the bad-key flag.
- R10: If an accepted write falls in the same cycle as a tick, the write wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_start | input | 1 | Command: 1 = start/kick, 0 = stop |
| wr_count | input | 8 | Start value for the counter |
| wr_key | input | 7 | Key presented with the write |
| nmi_req | output | 1 | One-cycle NMI request on reaching count 1 |
| chip_rst | output | 1 | Chip reset, held HOLD clocks on reaching 0 |
| st_running | output | 1 | Watchdog is counting |
| st_count | output | 8 | Present counter value |
| st_key | output | 7 | Last accepted key |
| st_bad_key | output | 1 | Sticky wrong-key flag |

## Verification
Two things can land on the same clock edge: an accepted control write and a prescaler tick. Which one takes effect decides whether a kick or a stop saves the chip at the last moment. The bench counts clocks from an accepted start and places a kick, and later a stop, exactly on the cycle where the prescaler tick is due. It also lets constrained-random writes collide with ticks at arbitrary points. Each result is judged against a cycle-level reference model in which the write takes precedence and the tick is lost.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
    parameter int unsigned DIV = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == PW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // R2: ticks are separated by at least one quiet cycle when dividing
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((DIV > 1) && tick) |=> !tick);
    // R2: a clear always postpones the next tick
    a_r2_clear_delays: assert property (@(posedge clk) disable iff (!rst_n)
        ((DIV > 1) && clr) |=> !tick);
endmodule

// File: rtl/kwd_keygate.sv
module kwd_keygate #(
    parameter int unsigned KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             blocked,
    output logic             accept,
    output logic [KEY_W-1:0] key_q,
    output logic             bad_q
);
    logic key_match;
    logic live_wr;

    assign key_match = (wr_key == ~key_q);
    assign live_wr   = wr_en && !blocked;
    assign accept    = live_wr && key_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            bad_q <= 1'b0;
        end else begin
            if (accept) begin
                key_q <= wr_key;
            end
            if (live_wr && !key_match) begin
                bad_q <= 1'b1;
            end
        end
    end

    // R3: each accepted write stores the inverse of the previous key
    a_r3_key_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (key_q == ~$past(key_q)));
    // R4: a rejected write keeps the stored key
    a_r4_reject_keeps_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(key_q));
    // R4: bad-key flag is sticky
    a_r4_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q |=> bad_q);
    // R9: writes during the reset hold leave the flag alone
    a_r9_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && blocked) |=> $stable(bad_q));
endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned HOLD  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_ok,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] load_val,
    output logic             nmi,
    output logic             chip_rst,
    output logic             running,
    output logic             biting,
    output logic [CNT_W-1:0] count
);
    localparam int unsigned HW = (HOLD > 1) ? $clog2(HOLD) : 1;

    wd_state_e        state, state_n;
    logic [CNT_W-1:0] cnt_n;
    logic [HW-1:0]    hold, hold_n;
    logic             nmi_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_IDLE;
            count <= '0;
            hold  <= '0;
            nmi   <= 1'b0;
        end else begin
            state <= state_n;
            count <= cnt_n;
            hold  <= hold_n;
            nmi   <= nmi_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = count;
        hold_n  = hold;
        nmi_n   = 1'b0;
        unique case (state)
            WD_IDLE: begin
                if (cmd_ok && cmd_start) begin
                    cnt_n   = load_val;
                    hold_n  = '0;
                    state_n = (load_val == '0) ? WD_BITE : WD_RUN;
                end
            end
            WD_RUN: begin
                if (cmd_ok) begin
                    if (cmd_start) begin
                        cnt_n   = load_val;
                        hold_n  = '0;
                        state_n = (load_val == '0) ? WD_BITE : WD_RUN;
                    end else begin
                        state_n = WD_IDLE;
                    end
                end else if (tick) begin
                    cnt_n = count - 1'b1;
                    if (count == CNT_W'(2)) begin
                        nmi_n = 1'b1;
                    end
                    if (count == CNT_W'(1)) begin
                        hold_n  = '0;
                        state_n = WD_BITE;
                    end
                end
            end
            WD_BITE: begin
                if (hold == HW'(HOLD - 1)) begin
                    hold_n  = '0;
                    state_n = WD_IDLE;
                end else begin
                    hold_n = hold + 1'b1;
                end
            end
            default: state_n = WD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running  = (state == WD_RUN);
        biting   = (state == WD_BITE);
        chip_rst = (state == WD_BITE);
    end

    // R7: the NMI request lasts a single cycle
    a_r7_nmi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi);
    // R7: the NMI request coincides with count 1
    a_r7_nmi_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> (count == CNT_W'(1)));
    // R2: an undisturbed tick while running steps the count down by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !cmd_ok) |=> (count == $past(count) - CNT_W'(1)));
    // R5: an accepted start loads the supplied value
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_start) |=> (count == $past(load_val)));
    // R6: an accepted stop halts counting
    a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && !cmd_start) |=> !running);
    // R8: a tick at count 1 enters the reset hold
    a_r8_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !cmd_ok && count == CNT_W'(1)) |=> chip_rst);
    // R8: reset stays up until the hold counter expires
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && hold != HW'(HOLD - 1)) |=> chip_rst);
    // R8: running and reset never overlap
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_rst && running));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned KEY_W = 7,
    parameter int unsigned DIV   = 131072,
    parameter int unsigned HOLD  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_start,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [KEY_W-1:0] wr_key,
    output logic             nmi_req,
    output logic             chip_rst,
    output logic             st_running,
    output logic [CNT_W-1:0] st_count,
    output logic [KEY_W-1:0] st_key,
    output logic             st_bad_key
);
    logic tick;
    logic accept;
    logic biting;
    logic pre_clr;

    assign pre_clr = accept && wr_start;

    kwd_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .tick  (tick)
    );

    kwd_keygate #(.KEY_W(KEY_W)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_key  (wr_key),
        .blocked (biting),
        .accept  (accept),
        .key_q   (st_key),
        .bad_q   (st_bad_key)
    );

    kwd_fsm #(.CNT_W(CNT_W), .HOLD(HOLD)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_ok    (accept),
        .cmd_start (wr_start),
        .load_val  (wr_count),
        .nmi       (nmi_req),
        .chip_rst  (chip_rst),
        .running   (st_running),
        .biting    (biting),
        .count     (st_count)
    );
endmodule

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
    localparam int DIV  = 8;
    localparam int HOLD = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_start = 1'b0;
    logic [7:0] wr_count = '0;
    logic [6:0] wr_key = '0;
    logic       nmi_req, chip_rst, st_running, st_bad_key;
    logic [7:0] st_count;
    logic [6:0] st_key;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state (0 idle, 1 run, 2 reset hold)
    int       m_st, m_cnt, m_hold, m_pre;
    bit       m_nmi, m_bad;
    bit [6:0] m_key;

    always #4 clk = ~clk;

    keyed_watchdog #(.DIV(DIV), .HOLD(HOLD)) i_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
        .wr_count(wr_count), .wr_key(wr_key), .nmi_req(nmi_req),
        .chip_rst(chip_rst), .st_running(st_running), .st_count(st_count),
        .st_key(st_key), .st_bad_key(st_bad_key)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit [6:0] inv(bit [6:0] k);
        return ~k;
    endfunction

    task automatic model_edge(bit w, bit s, int c, bit [6:0] k);
        bit tk = (m_pre == DIV - 1);
        bit ok = w && (m_st != 2) && (k == inv(m_key));
        m_nmi = 0;
        if (m_st == 2) begin
            if (m_hold == HOLD - 1) begin m_st = 0; m_hold = 0; end
            else m_hold++;
        end else if (ok) begin
            m_key = k;
            if (s) begin m_cnt = c; m_st = (c == 0) ? 2 : 1; m_hold = 0; end
            else m_st = 0;
        end else begin
            if (w) m_bad = 1;
            if (m_st == 1 && tk) begin
                m_cnt--;
                if (m_cnt == 1) m_nmi = 1;
                if (m_cnt == 0) begin m_st = 2; m_hold = 0; end
            end
        end
        if ((ok && s) || tk) m_pre = 0;
        else m_pre++;
    endtask

    task automatic compare();
        chk("R2 count", int'(st_count), m_cnt);
        chk("R3 stored key", int'(st_key), int'(m_key));
        chk("R4 bad-key flag", int'(st_bad_key), int'(m_bad));
        chk("R6 running", int'(st_running), int'(m_st == 1));
        chk("R7 nmi", int'(nmi_req), int'(m_nmi));
        chk("R8 chip reset", int'(chip_rst), int'(m_st == 2));
    endtask

    // one clock: drive after the falling edge, compare at the next falling edge
    task automatic cyc(bit w, bit s, int c, bit [6:0] k);
        wr_en = w; wr_start = s; wr_count = 8'(c); wr_key = k;
        @(posedge clk);
        model_edge(w, s, c, k);
        @(negedge clk);
        wr_en = 0;
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 7'h00);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        m_st = 0; m_cnt = 0; m_hold = 0; m_pre = 0; m_nmi = 0; m_bad = 0; m_key = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 running", int'(st_running), 0);
        chk("R1 count", int'(st_count), 0);
        chk("R1 key", int'(st_key), 0);
        chk("R1 bad", int'(st_bad_key), 0);
        chk("R1 nmi", int'(nmi_req), 0);
        chk("R1 reset", int'(chip_rst), 0);

        // R3: first start needs 7F; start value 1 bites without an NMI
        cyc(1, 1, 1, 7'h7F);
        chk("R3 first start accepted", int'(st_running), 1);
        idle(DIV);
        chk("R8 reset after count 1", int'(chip_rst), 1);
        // R9: correctly keyed write during reset hold is discarded
        cyc(1, 1, 3, 7'h00);
        chk("R9 key unchanged", int'(st_key), 7'h7F);
        chk("R9 bad flag unchanged", int'(st_bad_key), 0);
        idle(HOLD + 2);
        chk("R8 back to stopped", int'(st_running), 0);
        chk("R8 count left at 0", int'(st_count), 0);

        // R10: kick on the exact tick cycle wins over the tick
        cyc(1, 1, 3, 7'h00);
        idle(DIV - 1);
        cyc(1, 1, 5, 7'h7F);
        chk("R10 kick beats tick", int'(st_count), 5);
        idle(2 * DIV + 3);
        // R5: kick in mid-period reloads
        cyc(1, 1, 4, 7'h00);
        chk("R5 kick reload", int'(st_count), 4);
        // R4: repeated key rejected
        cyc(1, 1, 9, 7'h00);
        chk("R4 count kept", int'(st_count), 4);
        chk("R4 key kept", int'(st_key), 7'h00);
        chk("R4 bad set", int'(st_bad_key), 1);
        // R6: wrong-key stop, then correct stop freezes count
        cyc(1, 0, 0, 7'h00);
        chk("R6 wrong stop ignored", int'(st_running), 1);
        cyc(1, 0, 0, 7'h7F);
        chk("R6 stopped", int'(st_running), 0);
        idle(3 * DIV);
        chk("R6 count frozen", int'(st_count), 4);
        // R8: start value 0 bites at once
        cyc(1, 1, 0, 7'h00);
        chk("R8 load zero bites", int'(chip_rst), 1);
        idle(HOLD + 2);

        // R10 variant: stop on the tick cycle that would reach 1
        do_reset();
        cyc(1, 1, 3, 7'h7F);
        idle(2 * DIV - 1);
        cyc(1, 0, 0, 7'h00);
        chk("R10 stop beats tick", int'(st_count), 2);
        chk("R7 no nmi after stop", int'(nmi_req), 0);

        // R7: full run to NMI and reset, then constrained random traffic
        cyc(1, 1, 2, 7'h7F);
        idle(DIV);
        chk("R7 nmi pulse", int'(nmi_req), 1);
        idle(DIV + HOLD + 2);

        for (int i = 0; i < 4000; i++) begin
            bit w = ($urandom_range(0, 5) == 0);
            bit s = ($urandom_range(0, 3) != 0);
            int c = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 255))
                                                : int'($urandom_range(0, 4));
            bit [6:0] k = ($urandom_range(0, 9) < 7) ? inv(m_key)
                                                     : 7'($urandom_range(0, 127));
            cyc(w, s, c, k);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule